// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Line-Break Handling

This block is the receive half of an asynchronous serial port. The serial input is sampled at 16 times the bit rate, paced by a single-cycle `tick` strobe from an external rate generator. Each character is built from a start bit, 5 to 8 data bits, an optional parity bit and one stop bit. The result is then written, together with its parity, framing and break status, into a four-entry receive queue.

The receiver also handles the awkward cases on a serial line. After a framing error on a character with non-zero data, a line that is still low counts as a new start bit. A line held low for a whole character is a break, and it yields a single all-zero entry. A break that starts partway through a character first yields the damaged character and then the break entry. After a break, the line must stay high for half a bit before the receiver looks for a start bit again.

The queue is read through a valid/ready pair. While `out_valid` is high, the head entry is on `out_data` and the status pins. An entry is removed on every clock edge where `out_valid` and `out_ready` are both high. Back-pressure from the reader never stalls reception: a character that completes while the queue is full is dropped and sets a sticky overrun flag. An optional ready-to-receive output lets the far end throttle itself.

Top module: `uart_rx_brk`

## Requirements
- R1: Data bits arrive least significant bit first. `char_len` selects 5, 6, 7 or 8 data bits for the codes 0, 1, 2 and 3. Stored data bits above the character length read as zero.
- R2: A falling edge starts a character only if the line is still low at the mid-point of the start bit. A low pulse shorter than half a bit produces no entry.
- R3: When `par_en` is 1, one parity bit follows the data. `par_odd`=1 selects odd parity and 0 selects even parity. A mismatch sets `out_pe` on that entry.
- R4: A low stop bit on a character whose data is non-zero stores that character with `out_fe`=1. If the line is still low half a bit after the stop sample, that low is taken as the start bit of the next character.
- R5: A line that is low through every data, parity and stop bit stores one entry with data 0, `out_rb`=1, `out_fe`=0 and `out_pe`=0. A high pulse shorter than half a bit does not re-arm the receiver after a break. After at least half a bit of high line, the next character is received.
- R6: A break that begins inside a character first stores the damaged character with `out_fe`=1. If the line stays low through the next character time, it then stores exactly one all-zero entry with `out_rb`=1.
- R7: The queue holds 4 entries and hands them out in arrival order. `out_valid` is high while the queue is non-empty, and `fifo_full` is high while all 4 entries are occupied.
- R8: A character that completes while the queue is full is lost and sets `ovr`. `ovr` stays set until a cycle with `clr_ovr`=1.
- R9: `rts` is high whenever `rts_en`=0. When `rts_en`=1, `rts` is high only while the queue is not full and `ovr` is clear.
- R10: A character with all data bits zero but a high parity bit and a low stop bit is stored with `out_fe`=1 and `out_rb`=0. The receiver then waits for half a bit of high line before looking for a start bit, as it does after a break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Oversampling strobe, 16 per bit time |
| rxd | input | 1 | Serial input, idle high |
| char_len | input | 2 | Data bits minus 5 |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rts_en | input | 1 | Enable receive flow control |
| clr_ovr | input | 1 | Clear the overrun flag |
| out_ready | input | 1 | Reader accepts the head entry |
| out_valid | output | 1 | Head entry present |
| out_data | output | 8 | Head entry data |
| out_pe | output | 1 | Head entry parity error |
| out_fe | output | 1 | Head entry framing error |
| out_rb | output | 1 | Head entry is a break |
| fifo_full | output | 1 | All queue entries occupied |
| ovr | output | 1 | Sticky overrun flag |
| rts | output | 1 | Ready to receive |

## Verification
The hardest situation to reach from the ports is a break that starts in the middle of a character. It must produce two entries with different status: first the damaged character, then, exactly one character time later, the break entry. It must also not produce a third entry while the line stays low. The bench reaches this state by driving the first half of a real character and then holding the line low for more than two character times. The same long-low technique is used to pin down when the receiver re-arms after a framing error and after a break. A quarter-bit high glitch checks that re-arming waits for half a bit of high line.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_FECHK, S_BRKW
  } rx_state_t;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              pe;
    logic              fe;
    logic              rb;
  } rx_entry_t;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (!rst_n) sr <= '1;
    else        sr <= {sr[STAGES-2:0], din};
  end

  assign dout = sr[STAGES-1];
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      rx,
  input  logic [1:0] char_len,
  input  logic      par_en,
  input  logic      par_odd,
  output logic      push,
  output rx_entry_t entry
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] MID_C  = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] LAST_C = CW'(OSR - 1);

  rx_state_t         state;
  logic [CW-1:0]     cnt;
  logic [2:0]        bitn;
  logic [DATA_W-1:0] shreg;
  logic              parbit;
  logic              anyone;

  logic [2:0]        last_idx;
  logic [DATA_W-1:0] data_al;
  logic              at_mid, at_last, is_brk;

  assign last_idx = 3'd4 + {1'b0, char_len};
  assign data_al  = shreg >> (2'd3 - char_len);
  assign at_mid   = (cnt == MID_C);
  assign at_last  = (cnt == LAST_C);
  assign is_brk   = !anyone && !rx;

  assign push       = tick && (state == S_STOP) && at_last;
  assign entry.data = is_brk ? '0 : data_al;
  assign entry.pe   = !is_brk && par_en && ((^data_al ^ parbit) != par_odd);
  assign entry.fe   = !is_brk && !rx;
  assign entry.rb   = is_brk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      bitn   <= '0;
      shreg  <= '0;
      parbit <= 1'b0;
      anyone <= 1'b0;
    end else if (tick) begin
      case (state)
        S_IDLE: if (!rx) begin
          state <= S_START;
          cnt   <= '0;
        end
        S_START: begin
          if (at_mid) begin
            cnt <= '0;
            if (!rx) begin
              state  <= S_DATA;
              bitn   <= '0;
              shreg  <= '0;
              parbit <= 1'b0;
              anyone <= 1'b0;
            end else begin
              state <= S_IDLE;
            end
          end else cnt <= cnt + 1'b1;
        end
        S_DATA: begin
          if (at_last) begin
            cnt    <= '0;
            shreg  <= {rx, shreg[DATA_W-1:1]};
            anyone <= anyone | rx;
            if (bitn == last_idx) state <= par_en ? S_PAR : S_STOP;
            else                  bitn  <= bitn + 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        S_PAR: begin
          if (at_last) begin
            cnt    <= '0;
            parbit <= rx;
            anyone <= anyone | rx;
            state  <= S_STOP;
          end else cnt <= cnt + 1'b1;
        end
        S_STOP: begin
          if (at_last) begin
            cnt <= '0;
            if (rx)                state <= S_IDLE;
            else if (data_al != 0) state <= S_FECHK;
            else                   state <= S_BRKW;
          end else cnt <= cnt + 1'b1;
        end
        S_FECHK: begin
          if (at_mid) begin
            cnt   <= '0;
            state <= rx ? S_IDLE : S_START;
          end else cnt <= cnt + 1'b1;
        end
        S_BRKW: begin
          if (!rx)        cnt   <= '0;
          else if (at_mid) state <= S_IDLE;
          else            cnt   <= cnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R5
  brk_entry_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && entry.rb) |-> (entry.data == '0 && !entry.fe && !entry.pe));

  // R2
  start_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DATA && $past(state) != S_DATA) |-> $past(state) == S_START);
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int W     = 11,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop_ready,
  output logic         valid,
  output logic [W-1:0] rdata,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_C = (AW+1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   count;
  logic          push_acc, pop;

  assign valid    = (count != '0);
  assign full     = (count == FULL_C);
  assign push_acc = push && !full;
  assign pop      = valid && pop_ready;
  assign rdata    = mem[rptr];

  always_ff @(posedge clk) begin
    if (push_acc) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_acc) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
      if (pop)      rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
      case ({push_acc, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_C);

  // R7
  pop_drains_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push_acc) |=> count == $past(count) - 1'b1);
endmodule

// File: rtl/uart_rx_brk.sv
module uart_rx_brk
  import uart_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int FIFO_DEPTH  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  input  logic [1:0] char_len,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       rts_en,
  input  logic       clr_ovr,
  input  logic       out_ready,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_pe,
  output logic       out_fe,
  output logic       out_rb,
  output logic       fifo_full,
  output logic       ovr,
  output logic       rts
);
  localparam int EW = $bits(rx_entry_t);

  logic      rx_s;
  logic      core_push;
  rx_entry_t core_entry, head;
  logic [EW-1:0] head_bits;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rx_s)
  );

  uart_rx_core #(.OSR(OSR)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx(rx_s),
    .char_len(char_len), .par_en(par_en), .par_odd(par_odd),
    .push(core_push), .entry(core_entry)
  );

  uart_rx_fifo #(.W(EW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(core_push), .wdata(core_entry),
    .pop_ready(out_ready), .valid(out_valid), .rdata(head_bits),
    .full(fifo_full)
  );

  assign head     = rx_entry_t'(head_bits);
  assign out_data = head.data;
  assign out_pe   = head.pe;
  assign out_fe   = head.fe;
  assign out_rb   = head.rb;

  always_ff @(posedge clk) begin
    if (!rst_n)                      ovr <= 1'b0;
    else if (core_push && fifo_full) ovr <= 1'b1;
    else if (clr_ovr)                ovr <= 1'b0;
  end

  assign rts = !rts_en || (!fifo_full && !ovr);

  // R8
  ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(core_push && fifo_full));

  // R7
  pop_from_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && out_ready) |=> !fifo_full);

  // R9
  rts_low_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rts_en && fifo_full) |-> !rts);
endmodule

// File: tb/tb_uart_rx_brk.sv
module tb_uart_rx_brk;
  localparam int BITC = 64;

  logic clk = 0, rst_n = 0, tick = 0, rxd = 1;
  logic [1:0] char_len = 2'd3;
  logic par_en = 0, par_odd = 0, rts_en = 0, clr_ovr = 0, out_ready = 0;
  logic out_valid, out_pe, out_fe, out_rb, fifo_full, ovr, rts;
  logic [7:0] out_data;
  int checks = 0, errors = 0;
  logic [1:0] tdiv = 0;

  uart_rx_brk dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .char_len(char_len),
    .par_en(par_en), .par_odd(par_odd), .rts_en(rts_en), .clr_ovr(clr_ovr),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .out_pe(out_pe), .out_fe(out_fe), .out_rb(out_rb),
    .fifo_full(fifo_full), .ovr(ovr), .rts(rts)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) begin
    tdiv <= tdiv + 1'b1;
    tick <= (tdiv == 2'd3);
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input int n);
    @(negedge clk) rxd = v;
    repeat (n - 1) @(negedge clk);
  endtask

  function automatic logic [7:0] mask_len(input logic [7:0] d, input logic [1:0] l);
    return d & 8'(8'hFF >> (2'd3 - l));
  endfunction

  function automatic logic par_bit(input logic [7:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  // frame with choice of parity corruption and stop handling; 1 bit idle after
  task automatic send_char(input logic [7:0] d, input logic bad_par, input logic bad_stop);
    drive(0, BITC);
    for (int i = 0; i < 5 + char_len; i++) drive(d[i], BITC);
    if (par_en) drive(par_bit(d, par_odd) ^ bad_par, BITC);
    if (bad_stop) begin
      drive(0, 48);
      drive(1, 16);
    end else drive(1, BITC);
    drive(1, BITC);
  endtask

  task automatic expect_entry(input logic [7:0] d, input logic pe, input logic fe,
                              input logic rb, input string req);
    int w = 0;
    while (!out_valid && w < 3000) begin
      @(negedge clk);
      w++;
    end
    chk({out_valid, out_data, out_pe, out_fe, out_rb} == {1'b1, d, pe, fe, rb}, req,
        {out_valid, out_data, out_pe, out_fe, out_rb}, {1'b1, d, pe, fe, rb});
    out_ready = 1;
    @(negedge clk) out_ready = 0;
  endtask

  task automatic expect_empty(input string req);
    repeat (4 * BITC) @(negedge clk);
    chk(!out_valid, req, out_valid, 0);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic bp, bs;
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R7 R9 reset state
    chk(!out_valid && !fifo_full, "R7", {out_valid, fifo_full}, 0);
    chk(!ovr && rts, "R9", {ovr, rts}, 1);

    // R2 short glitch
    drive(0, 16);
    drive(1, BITC);
    expect_empty("R2");

    // R1 directed: 5-bit length clears upper bits
    char_len = 2'd0;
    send_char(8'hFF, 0, 0);
    expect_entry(8'h1F, 0, 0, 0, "R1");
    char_len = 2'd3;
    send_char(8'hA6, 0, 0);
    expect_entry(8'hA6, 0, 0, 0, "R1");

    // R3 directed parity
    par_en = 1; par_odd = 1;
    send_char(8'h3C, 1, 0);
    expect_entry(8'h3C, 1, 0, 0, "R3");
    par_odd = 0;
    send_char(8'h3D, 0, 0);
    expect_entry(8'h3D, 0, 0, 0, "R3");
    par_en = 0;

    // random mix: R1 R3 R4
    for (int n = 0; n < 40; n++) begin
      char_len = 2'($urandom_range(0, 3));
      par_en   = 1'($urandom_range(0, 1));
      par_odd  = 1'($urandom_range(0, 1));
      bp       = ($urandom_range(0, 3) == 0);
      bs       = ($urandom_range(0, 4) == 0);
      d        = mask_len(8'($urandom), char_len);
      if (bs) d[0] = 1'b1;
      send_char(d, bp, bs);
      expect_entry(d, par_en && bp, bs, 0, bs ? "R4" : (bp ? "R3" : "R1"));
    end
    char_len = 2'd3; par_en = 0;

    // R4 framing error then low taken as next start
    drive(0, BITC);
    for (int i = 0; i < 8; i++) drive(i[0] ? 1'b0 : 1'b1, BITC); // 0x55
    drive(0, BITC);                                             // bad stop
    drive(0, BITC);                                             // next start
    for (int i = 0; i < 8; i++) drive(8'hA3 >> i, BITC);
    drive(1, 2 * BITC);
    expect_entry(8'h55, 0, 1, 0, "R4");
    expect_entry(8'hA3, 0, 0, 0, "R4");

    // R5 full break, short high glitch does not re-arm
    drive(0, 12 * BITC);
    drive(1, 16);
    drive(0, 10 * BITC);
    drive(1, 2 * BITC);
    expect_entry(8'h00, 0, 0, 1, "R5");
    expect_empty("R5");
    send_char(8'h81, 0, 0);
    expect_entry(8'h81, 0, 0, 0, "R5");

    // R6 mid-character break
    drive(0, BITC);
    for (int i = 0; i < 4; i++) drive(1, BITC);
    drive(0, 20 * BITC);
    drive(1, 2 * BITC);
    expect_entry(8'h0F, 0, 1, 0, "R6");
    expect_entry(8'h00, 0, 0, 1, "R6");
    expect_empty("R6");

    // R10 zero data, high parity, low stop
    par_en = 1; par_odd = 1;
    drive(0, BITC);
    for (int i = 0; i < 8; i++) drive(0, BITC);
    drive(1, BITC);
    drive(0, 13 * BITC);
    drive(1, 2 * BITC);
    expect_entry(8'h00, 0, 1, 0, "R10");
    expect_empty("R10");
    par_en = 0;

    // R7 R8 R9 fill, overrun, drain
    rts_en = 1;
    for (int i = 0; i < 4; i++) send_char(8'h10 + 8'(i), 0, 0);
    @(negedge clk);
    chk(fifo_full && !ovr, "R7", {fifo_full, ovr}, 2);
    chk(!rts, "R9", rts, 0);
    rts_en = 0;
    @(negedge clk);
    chk(rts, "R9", rts, 1);
    rts_en = 1;
    send_char(8'h55, 0, 0);
    chk(ovr, "R8", ovr, 1);
    for (int i = 0; i < 4; i++) expect_entry(8'h10 + 8'(i), 0, 0, 0, "R7");
    @(negedge clk);
    chk(!out_valid && ovr && !rts, "R8", {out_valid, ovr, rts}, 2);
    clr_ovr = 1;
    @(negedge clk) clr_ovr = 0;
    @(negedge clk);
    chk(!ovr && rts, "R9", {ovr, rts}, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule